// File: doc/BRIEF.md
# Serial Frame Alignment Lock Monitor

This block watches a serial bitstream that is divided into frames of a fixed length (512 bits by default). One bit of every frame, always at the same bit position, is an alignment bit. Taken one per frame, the alignment bits repeat an 8-bit cyclic marker. The block does not know where in the frame that position lies, or where in the marker the stream starts. It tries candidate bit phases one at a time. It declares frame lock once the marker has been seen three times in a row at one phase.

After lock, every alignment bit is compared with the bit the marker predicts. A single wrong bit is treated as noise if the next four alignment bits are clean. A second error inside that window drops lock, and a new search begins. An active-low interrupt, a sticky lock-lost flag, the current phase and a saturating count of locked frames are reported. The host can force a loss, clear the status with a read strobe, or switch framing off so that lock is always reported. The received bits are passed on one cycle later, with the alignment bits marked.

Top module: `fa_lock_monitor`

## Requirements
- R1: After reset, with framing enabled, the outputs are as follows: `locked`=0, `lock_lost`=0, `irq_n`=1, `frame_cnt`=0 and `phase`=0.
- R2: The search tests one candidate phase at a time, starting at phase 0, and `phase` shows the candidate. At the candidate's first mismatch the candidate moves to the next bit position, wrapping at the frame length, and the new candidate's first slot is the very next bit.
- R3: The marker is 00011011, with the leftmost bit sent first, and the stream may start at any point of it. Lock is declared on the 24th consecutive alignment bit at one candidate phase for which the first 8 bits form a rotation of the marker and each later bit equals the bit 8 frames before it. `locked` rises on the edge that accepts that bit.
- R4: While locked, one mismatching alignment bit followed by four matching ones leaves `locked`=1, `lock_lost`=0 and `irq_n`=1. A mismatch five frames after the first one starts a new window and does not drop lock.
- R5: While locked, a mismatch followed by another mismatch within the next four alignment bits drops `locked` on the edge that accepts the second mismatch and sets `lock_lost`. The search then resumes at the same phase, so a clean stream relocks on its 24th slot after the loss.
- R6: `irq_n` goes low when lock is declared and when lock is lost without host force. A one-cycle `stat_rd` pulse returns `irq_n` to 1 and clears `lock_lost`.
- R7: A `force_loss` pulse while locked drops `locked` and sets `lock_lost` but leaves `irq_n` high. The following relock still drives `irq_n` low.
- R8: `frame_cnt` adds one for each alignment bit accepted while locked. The bit that declares lock is not counted. The count saturates at 2^CNT_W-1.
- R9: With `framing_en`=0, `locked` reads 1 whatever the data, and no interrupt is raised. Setting `framing_en` to 1 again restarts the search with `locked`=0.
- R10: `out_bit` and `out_vld` repeat `bit_in` and `bit_vld` one cycle later. `out_align` is high, together with `out_vld`, exactly for an alignment bit accepted while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| framing_en | input | 1 | 1: search and monitor alignment; 0: report permanent lock |
| bit_vld | input | 1 | A stream bit is present on `bit_in` this cycle |
| bit_in | input | 1 | Serial stream bit |
| force_loss | input | 1 | Host pulse that drops lock without an interrupt |
| stat_rd | input | 1 | Host status read pulse; clears `irq_n` and `lock_lost` |
| locked | output | 1 | Frame lock held (always 1 in bypass) |
| lock_lost | output | 1 | Sticky: lock has been lost since the last read |
| irq_n | output | 1 | Active-low alignment interrupt |
| phase | output | $clog2(FRAME_BITS) | Candidate or locked bit phase within the frame |
| frame_cnt | output | CNT_W | Saturating count of locked frames |
| out_bit | output | 1 | Stream bit, delayed one cycle |
| out_vld | output | 1 | Valid for `out_bit` |
| out_align | output | 1 | `out_bit` is an alignment bit of a locked frame |

## Verification
The assertions assume that `bit_vld` marks single stream bits. They also assume that `framing_en` changes only in cycles without a stream bit, and that `force_loss` and `stat_rd` are one-cycle pulses. Under these assumptions, every edge of `locked` and every fall of `irq_n` can be traced to an accepted bit or to a host action. The stimulus respects them: random idle gaps are placed between the bits, control pulses and mode changes are applied only in idle cycles, and the frame length is reduced so that a full phase sweep fits in a short run. Errors are injected only into alignment bits, at chosen frame distances from the lock point.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_LOCKED  = 2'd1,
    ST_CONFIRM = 2'd2
  } fa_state_e;
endpackage

// File: rtl/fa_bit_position.sv
module fa_bit_position #(
  parameter int FRAME_BITS = 512,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] pos
);
  logic [PW-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (adv) begin
      if (pos_q == PW'(FRAME_BITS - 1)) pos_d = '0;
      else                               pos_d = pos_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;
endmodule

// File: rtl/fa_lock_fsm.sv
module fa_lock_fsm
  import fa_pkg::*;
#(
  parameter int          FRAME_BITS    = 512,
  parameter int          PAT_W         = 8,
  parameter logic [PAT_W-1:0] ALIGN_PAT = 8'b00011011,
  parameter int          REPEATS       = 3,
  parameter int          CONFIRM_SLOTS = 4,
  localparam int PW         = $clog2(FRAME_BITS),
  localparam int LOCK_SLOTS = PAT_W * REPEATS,
  localparam int CW         = $clog2(LOCK_SLOTS),
  localparam int KW         = $clog2(CONFIRM_SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          framing_en,
  input  logic          bit_vld,
  input  logic          bit_in,
  input  logic [PW-1:0] pos,
  input  logic          force_loss,
  output fa_state_e     state,
  output logic [PW-1:0] cand,
  output logic          lock_evt,
  output logic          loss_evt,
  output logic          loss_forced,
  output logic          frame_inc,
  output logic          align_slot
);
  localparam logic [2*PAT_W-1:0] PAT_DBL = {ALIGN_PAT, ALIGN_PAT};

  fa_state_e      state_q, state_d;
  logic [PW-1:0]  cand_q, cand_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [KW-1:0]  conf_q, conf_d;
  logic [PAT_W-1:0] sr_q, sr_d;

  logic [PAT_W-1:0] win;
  logic [PAT_W-1:0] rot_hit;
  logic             slot;
  logic             expect_bit;

  assign win        = {sr_q[PAT_W-2:0], bit_in};
  assign expect_bit = sr_q[PAT_W-1];
  assign slot       = bit_vld && framing_en && (pos == cand_q);

  // One comparator per rotation of the marker
  for (genvar g = 0; g < PAT_W; g++) begin : g_rot
    assign rot_hit[g] = (win == PAT_DBL[2*PAT_W-1-g -: PAT_W]);
  end

  always_comb begin
    state_d     = state_q;
    cand_d      = cand_q;
    cnt_d       = cnt_q;
    conf_d      = conf_q;
    sr_d        = sr_q;
    lock_evt    = 1'b0;
    loss_evt    = 1'b0;
    loss_forced = 1'b0;
    frame_inc   = 1'b0;

    if (!framing_en) begin
      state_d = ST_SEARCH;
      cnt_d   = '0;
      conf_d  = '0;
    end else if (force_loss) begin
      if (state_q != ST_SEARCH) begin
        loss_evt    = 1'b1;
        loss_forced = 1'b1;
      end
      state_d = ST_SEARCH;
      cnt_d   = '0;
      conf_d  = '0;
    end else if (slot) begin
      unique case (state_q)
        ST_SEARCH: begin
          if (cnt_q < CW'(PAT_W - 1)) begin
            sr_d  = win;
            cnt_d = cnt_q + CW'(1);
          end else if ((cnt_q == CW'(PAT_W - 1)) ? (|rot_hit) : (bit_in == expect_bit)) begin
            sr_d = win;
            if (cnt_q == CW'(LOCK_SLOTS - 1)) begin
              state_d  = ST_LOCKED;
              cnt_d    = '0;
              lock_evt = 1'b1;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end else begin
            cnt_d = '0;
            if (cand_q == PW'(FRAME_BITS - 1)) cand_d = '0;
            else                                cand_d = cand_q + PW'(1);
          end
        end
        ST_LOCKED: begin
          sr_d      = {sr_q[PAT_W-2:0], expect_bit};
          frame_inc = 1'b1;
          if (bit_in != expect_bit) begin
            state_d = ST_CONFIRM;
            conf_d  = KW'(CONFIRM_SLOTS);
          end
        end
        ST_CONFIRM: begin
          if (bit_in != expect_bit) begin
            state_d  = ST_SEARCH;
            cnt_d    = '0;
            conf_d   = '0;
            loss_evt = 1'b1;
          end else begin
            sr_d      = {sr_q[PAT_W-2:0], expect_bit};
            frame_inc = 1'b1;
            conf_d    = conf_q - KW'(1);
            if (conf_q == KW'(1)) state_d = ST_LOCKED;
          end
        end
        default: state_d = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      cand_q  <= '0;
      cnt_q   <= '0;
      conf_q  <= '0;
      sr_q    <= '0;
    end else begin
      state_q <= state_d;
      cand_q  <= cand_d;
      cnt_q   <= cnt_d;
      conf_q  <= conf_d;
      sr_q    <= sr_d;
    end
  end

  assign state      = state_q;
  assign cand       = cand_q;
  assign align_slot = slot && (state_q != ST_SEARCH);
endmodule

// File: rtl/fa_sat_counter.sv
module fa_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && (cnt_q != {W{1'b1}})) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/fa_alert.sv
module fa_alert (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_evt,
  input  logic loss_evt,
  input  logic loss_forced,
  input  logic stat_rd,
  output logic irq_n,
  output logic lock_lost
);
  logic irq_q, irq_d;
  logic lost_q, lost_d;

  always_comb begin
    irq_d  = lock_evt || (loss_evt && !loss_forced) || (irq_q && !stat_rd);
    lost_d = loss_evt || (lost_q && !stat_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      lost_q <= lost_d;
    end
  end

  assign irq_n     = !irq_q;
  assign lock_lost = lost_q;
endmodule

// File: rtl/fa_lock_monitor.sv
module fa_lock_monitor
  import fa_pkg::*;
#(
  parameter int FRAME_BITS    = 512,
  parameter int CNT_W         = 16,
  parameter int REPEATS       = 3,
  parameter int CONFIRM_SLOTS = 4,
  parameter logic [7:0] ALIGN_PAT = 8'b00011011,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             framing_en,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             force_loss,
  input  logic             stat_rd,
  output logic             locked,
  output logic             lock_lost,
  output logic             irq_n,
  output logic [PW-1:0]    phase,
  output logic [CNT_W-1:0] frame_cnt,
  output logic             out_bit,
  output logic             out_vld,
  output logic             out_align
);
  logic [PW-1:0] pos;
  fa_state_e     state;
  logic          lock_evt, loss_evt, loss_forced, frame_inc, align_slot;
  logic          obit_q, ovld_q, oalign_q;

  fa_bit_position #(.FRAME_BITS(FRAME_BITS)) u_pos (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (bit_vld),
    .pos   (pos)
  );

  fa_lock_fsm #(
    .FRAME_BITS    (FRAME_BITS),
    .PAT_W         (8),
    .ALIGN_PAT     (ALIGN_PAT),
    .REPEATS       (REPEATS),
    .CONFIRM_SLOTS (CONFIRM_SLOTS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .framing_en  (framing_en),
    .bit_vld     (bit_vld),
    .bit_in      (bit_in),
    .pos         (pos),
    .force_loss  (force_loss),
    .state       (state),
    .cand        (phase),
    .lock_evt    (lock_evt),
    .loss_evt    (loss_evt),
    .loss_forced (loss_forced),
    .frame_inc   (frame_inc),
    .align_slot  (align_slot)
  );

  fa_sat_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (frame_inc),
    .cnt   (frame_cnt)
  );

  fa_alert u_alert (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_evt    (lock_evt),
    .loss_evt    (loss_evt),
    .loss_forced (loss_forced),
    .stat_rd     (stat_rd),
    .irq_n       (irq_n),
    .lock_lost   (lock_lost)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obit_q   <= 1'b0;
      ovld_q   <= 1'b0;
      oalign_q <= 1'b0;
    end else begin
      ovld_q   <= bit_vld;
      oalign_q <= align_slot;
      if (bit_vld) obit_q <= bit_in;
    end
  end

  assign locked    = !framing_en || (state != ST_SEARCH);
  assign out_bit   = obit_q;
  assign out_vld   = ovld_q;
  assign out_align = oalign_q;
endmodule

// File: rtl/fa_lock_monitor_chk.sv
module fa_lock_monitor_chk #(
  parameter int FRAME_BITS = 512,
  parameter int CNT_W      = 16,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             framing_en,
  input logic             bit_vld,
  input logic             locked,
  input logic             irq_n,
  input logic [PW-1:0]    phase,
  input logic [CNT_W-1:0] frame_cnt,
  input logic             out_vld,
  input logic             out_align
);
  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PW'(FRAME_BITS - 1));

  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (framing_en && $past(framing_en) && $past(locked)) |-> (phase == $past(phase)));

  p_lock_on_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(locked) && framing_en && $past(framing_en)) |-> $past(bit_vld));

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($rose(locked) || $fell(locked)));

  p_cnt_monotonic_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt >= $past(frame_cnt));

  p_bypass_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !framing_en |-> locked);

  p_pass_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> out_vld);

  p_align_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_align |-> out_vld);
endmodule

bind fa_lock_monitor fa_lock_monitor_chk #(
  .FRAME_BITS (FRAME_BITS),
  .CNT_W      (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .framing_en (framing_en),
  .bit_vld    (bit_vld),
  .locked     (locked),
  .irq_n      (irq_n),
  .phase      (phase),
  .frame_cnt  (frame_cnt),
  .out_vld    (out_vld),
  .out_align  (out_align)
);

// File: tb/fa_lock_monitor_bench.sv
module fa_lock_monitor_bench;
  localparam int F  = 16;
  localparam int CW = 4;
  localparam logic [7:0] PAT = 8'b00011011;

  logic clk, rst_n, framing_en, bit_vld, bit_in, force_loss, stat_rd;
  logic locked, lock_lost, irq_n, out_bit, out_vld, out_align;
  logic [3:0] phase;
  logic [CW-1:0] frame_cnt;

  int checks = 0;
  int errors = 0;
  int gidx, A, K, flip1, flip2, lock_idx, firstA;

  fa_lock_monitor #(.FRAME_BITS(F), .CNT_W(CW)) u_fa_lock_monitor (
    .clk(clk), .rst_n(rst_n), .framing_en(framing_en), .bit_vld(bit_vld),
    .bit_in(bit_in), .force_loss(force_loss), .stat_rd(stat_rd),
    .locked(locked), .lock_lost(lock_lost), .irq_n(irq_n), .phase(phase),
    .frame_cnt(frame_cnt), .out_bit(out_bit), .out_vld(out_vld), .out_align(out_align)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit stream_bit(input int idx);
    int fr = idx / F;
    bit b;
    if (idx % F == A) begin
      b = PAT[7 - ((K + fr) % 8)];
      if (fr == flip1 || fr == flip2) b = ~b;
    end else begin
      b = 1'($urandom);
    end
    return b;
  endfunction

  task automatic idle();
    bit_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_one();
    bit b;
    bit exp_align;
    if ($urandom % 4 == 0) idle();
    b = stream_bit(gidx);
    exp_align = (gidx % F == A) && locked && framing_en;
    bit_in  = b;
    bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
    // R10: one-cycle pass-through and alignment marking
    chk(out_vld && out_bit == b, "R10 pass", int'(out_bit), int'(b));
    chk(out_align == exp_align, "R10 align", int'(out_align), int'(exp_align));
    if (locked && lock_idx < 0) lock_idx = gidx;
    if (phase == 4'(A) && firstA == -2) firstA = gidx;
    gidx++;
  endtask

  task automatic send_until(input int last);
    while (gidx <= last) send_one();
  endtask

  task automatic pulse_rd();
    stat_rd = 1'b1;
    idle();
    stat_rd = 1'b0;
  endtask

  function automatic int next_slot(input int from);
    int s = from;
    while (s % F != A) s++;
    return s;
  endfunction

  task automatic run(input int a, input int k);
    int exp_lock, lf, loss_idx, n;
    A = a; K = k; flip1 = -10; flip2 = -10;
    rst_n = 1'b0; framing_en = 1'b1; bit_vld = 1'b0; bit_in = 1'b0;
    force_loss = 1'b0; stat_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!locked && !lock_lost && irq_n && frame_cnt == 0 && phase == 0, "R1 reset",
        int'({locked, lock_lost, irq_n}), 1);
    gidx = 0; lock_idx = -1;
    firstA = (phase == 4'(A)) ? -1 : -2;
    while (lock_idx < 0 && gidx < F * (F * 24 + 40)) send_one();
    // R2 and R3: search reaches phase A, lock on the 24th slot there
    exp_lock = next_slot(firstA + 1) + 23 * F;
    chk(lock_idx == exp_lock, "R3 lock slot", lock_idx, exp_lock);
    chk(phase == 4'(A), "R2 phase", int'(phase), A);
    chk(!irq_n, "R6 irq at lock", int'(irq_n), 0);
    pulse_rd();
    chk(irq_n, "R6 read clears", int'(irq_n), 1);
    lf = lock_idx / F;
    send_until(lock_idx + 5 * F);
    chk(frame_cnt == 5, "R8 count", int'(frame_cnt), 5);
    // R4: isolated errors, second one just after the window
    flip1 = lf + 7; flip2 = lf + 12;
    send_until((lf + 21) * F - 1);
    chk(locked && !lock_lost && irq_n, "R4 noise ignored",
        int'({locked, lock_lost, irq_n}), 5);
    chk(frame_cnt == 4'hF, "R8 saturate", int'(frame_cnt), 15);
    // R5: second error on the fourth window bit
    flip1 = lf + 25; flip2 = lf + 29;
    loss_idx = (lf + 29) * F + A;
    send_until(loss_idx - 1);
    chk(locked, "R5 held before", int'(locked), 1);
    send_until(loss_idx);
    chk(!locked && lock_lost, "R5 loss", int'({locked, lock_lost}), 1);
    chk(phase == 4'(A), "R5 phase kept", int'(phase), A);
    chk(!irq_n, "R6 irq at loss", int'(irq_n), 0);
    pulse_rd();
    chk(irq_n && !lock_lost, "R6 read clears loss", int'({irq_n, lock_lost}), 2);
    send_until(loss_idx + 24 * F - 1);
    chk(!locked, "R5 not yet", int'(locked), 0);
    send_until(loss_idx + 24 * F);
    chk(locked && !irq_n, "R5 relock", int'({locked, irq_n}), 2);
    pulse_rd();
    // R7: forced loss
    force_loss = 1'b1;
    idle();
    force_loss = 1'b0;
    chk(!locked && lock_lost && irq_n, "R7 forced", int'({locked, lock_lost, irq_n}), 3);
    pulse_rd();
    n = next_slot(gidx) + 23 * F;
    send_until(n);
    chk(locked && !irq_n, "R7 relock irq", int'({locked, irq_n}), 2);
    pulse_rd();
    // R9: bypass
    framing_en = 1'b0;
    idle();
    flip1 = gidx / F + 1; flip2 = gidx / F + 2;
    send_until(gidx + 4 * F);
    chk(locked && irq_n, "R9 bypass", int'({locked, irq_n}), 3);
    framing_en = 1'b1;
    idle();
    chk(!locked, "R9 restart", int'(locked), 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    run(5, 3);
    run(int'($urandom % F), int'($urandom % 8));
    run(0, 7);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 190000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule